// File: doc/BRIEF.md
# System Clock Control Unit

This block is the system control register file of a small microcontroller subsystem. It holds read-only identification and capability words, a brown-out control word, a regulator (LDO) control word and a reset-cause word. It also holds two clock configuration words, three sets of clock-gating words and a small interrupt controller. From whichever clock configuration word is active, it drives a clock period scale to the other peripherals. It posts a PLL-lock interrupt as soon as software takes the PLL out of power-down. A crystal-index lookup returns a PLL configuration word from a per-class table. The PLL is not modelled. Peripheral reset is not modelled.

Software reaches the block through a single-cycle word-addressed port. A write takes effect on the clock edge where `wr_en` is high. `rdata` is registered: it shows the word addressed in cycle t from cycle t+1 on. The parameter `NEW_CLASS` selects the device class. The newer class (1) has a working extended clock word. The older class (0) ignores writes to that word, and it reads as zero.

Top module: `sysctl_unit`

## Requirements
- R1: After reset the main clock word (address 10) reads `CFG_RESET_VAL` (default 0x078E3AC0). The extended clock word (address 11) reads 0x07802810 in the newer class and 0 in the older class. Every other writable word reads 0, `irq` is low, and `clk_scale` is 80 for the default reset value.
- R2: When bit 31 of the extended word is 0, `clk_scale` equals 5 × (main word bits [26:23] + 1).
- R3: When bit 31 of the extended word is 1, `clk_scale` equals 5 × (extended word bits [28:23] + 1). After a write to either clock word, `clk_scale` shows the new value in the cycle after the write edge.
- R4: The raw interrupt status word is at address 13, and the PLL-lock flag is bit 6. A write to either clock word whose bit 13 turns from 1 to 0 sets that flag. Writes that keep bit 13 at 0, keep it at 1, or raise it leave the flag unchanged.
- R5: The interrupt mask word (address 14) keeps bits [6:0], and its upper bits read 0. The masked status word (address 15) reads raw AND mask, and `irq` is high exactly while that value is non-zero.
- R6: A write to the masked status word (address 15) clears every raw status bit written as 1 and leaves the other raw bits unchanged.
- R7: The brown-out word (address 7) keeps 16 bits, the LDO word (address 8) keeps 5 bits and the reset-cause word (address 9) keeps 6 bits. Unkept bits read 0.
- R8: The PLL configuration word (address 12, read-only) uses main word bits [9:6] as an index i. It returns 0x5A00 + i in the older class and 0xC300 + 3·i in the newer class.
- R9: In the older class a write to the extended word is ignored: that word still reads 0, and neither `clk_scale` nor the lock flag changes.
- R10: Nine 32-bit clock-gating words at addresses 16 to 24 (set s, word w at 16 + 3s + w) are fully read/write, reset to 0 and do not alias.
- R11: The seven words at addresses 0 to 6 read word k of `ID_WORDS` (bits [32k+31:32k]) and ignore writes.
- R12: Addresses 25 to 31 read 0 whatever has been written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data of the word addressed in the previous cycle |
| irq | output | 1 | High while masked status is non-zero |
| clk_scale | output | SCALE_W | Clock period scale for other peripherals |

## Verification
The bench sweeps all 16 main-word divisor codes and all 64 extended-word divisor codes. A design that picked the wrong field, dropped the +1 or ignored the override bit would give a wrong scale on some code. It also sweeps all 16 crystal indices in both device classes side by side, so a swapped table or an off-by-one index shows up at once. The lock interrupt is tried with all four transitions of bit 13 and with partial clear masks, which catches a design that sets the flag on any write to a clock word or clears bits written as 0. The older-class instance gets the same extended-word writes as the newer one, which shows any leak through to its scale or its lock flag.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ID_COUNT = 7;
  localparam int unsigned A_BOR    = 7;
  localparam int unsigned A_LDO    = 8;
  localparam int unsigned A_RSTC   = 9;
  localparam int unsigned A_CFG    = 10;
  localparam int unsigned A_CFG2   = 11;
  localparam int unsigned A_PLL    = 12;
  localparam int unsigned A_RAW    = 13;
  localparam int unsigned A_MASK   = 14;
  localparam int unsigned A_MSTAT  = 15;
  localparam int unsigned A_GATE   = 16;

  // PLL configuration word for a crystal index, per device class
  function automatic logic [15:0] pll_word(input logic is_new, input logic [3:0] idx);
    if (is_new) pll_word = 16'hC300 + 16'({idx, 1'b0}) + 16'(idx);
    else        pll_word = 16'h5A00 + 16'(idx);
  endfunction
endpackage

// File: rtl/sysctl_clkcfg.sv
module sysctl_clkcfg #(
  parameter bit              NEW_CLASS      = 1'b1,
  parameter logic [31:0]     CFG_RESET_VAL  = 32'h078E_3AC0,
  parameter logic [31:0]     CFG2_RESET_VAL = 32'h0780_2810,
  parameter int unsigned     SCALE_W        = 9,
  parameter int unsigned     PD_BIT         = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_cfg,
  input  logic               wr_cfg2,
  input  logic [31:0]        wdata,
  output logic [31:0]        cfg_q,
  output logic [31:0]        cfg2_q,
  output logic               lock_set,
  output logic [SCALE_W-1:0] scale
);
  logic cfg2_drop;

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= CFG_RESET_VAL;
    else if (wr_cfg) cfg_q <= wdata;
  end

  generate
    if (NEW_CLASS) begin : g_ext
      always_ff @(posedge clk) begin
        if (rst)          cfg2_q <= CFG2_RESET_VAL;
        else if (wr_cfg2) cfg2_q <= wdata;
      end
      assign cfg2_drop = wr_cfg2 & cfg2_q[PD_BIT] & ~wdata[PD_BIT];
    end else begin : g_noext
      assign cfg2_q    = '0;
      assign cfg2_drop = 1'b0;
    end
  endgenerate

  assign lock_set = (wr_cfg & cfg_q[PD_BIT] & ~wdata[PD_BIT]) | cfg2_drop;

  logic [5:0]         div_field;
  logic [SCALE_W-1:0] div_plus;
  always_comb begin
    div_field = cfg2_q[31] ? cfg2_q[28:23] : {2'b00, cfg_q[26:23]};
    div_plus  = SCALE_W'(div_field) + SCALE_W'(1);
    scale     = (div_plus << 2) + div_plus;
  end

  // R3: scale stays a multiple of five within the field's range
  a_r3_scale_range: assert property (@(posedge clk) disable iff (rst)
    (scale >= SCALE_W'(5)) && (scale <= SCALE_W'(320)) && ((scale % SCALE_W'(5)) == '0));
endmodule

// File: rtl/sysctl_irq.sv
module sysctl_irq #(
  parameter int unsigned IRQ_W    = 7,
  parameter int unsigned LOCK_BIT = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_lock,
  input  logic             wr_mask,
  input  logic             wr_clr,
  input  logic [IRQ_W-1:0] wbits,
  output logic [IRQ_W-1:0] raw_q,
  output logic [IRQ_W-1:0] mask_q,
  output logic             irq
);
  logic [IRQ_W-1:0] clr_bits;
  logic [IRQ_W-1:0] set_bits;

  assign clr_bits = wr_clr ? wbits : '0;
  assign set_bits = set_lock ? (IRQ_W'(1) << LOCK_BIT) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_bits) | set_bits;
      if (wr_mask) mask_q <= wbits;
    end
  end

  assign irq = |(raw_q & mask_q);

  // R4: a lock event is visible in the raw status the next cycle
  a_r4_lock_posts: assert property (@(posedge clk) disable iff (rst)
    set_lock |=> raw_q[LOCK_BIT]);
  // R6: bits written as one to the clear word are gone afterwards
  a_r6_clear_ones: assert property (@(posedge clk) disable iff (rst)
    (wr_clr && !set_lock) |=> ((raw_q & $past(wbits)) == '0));
  // R5: a zero mask keeps the output low
  a_r5_mask_gates: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |-> !irq);
endmodule

// File: rtl/sysctl_gate.sv
module sysctl_gate #(
  parameter int unsigned GATE_N = 9,
  parameter int unsigned IDX_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] widx,
  input  logic [31:0]      wdata,
  output logic [31:0]      gate_q [GATE_N]
);
  generate
    for (genvar g = 0; g < GATE_N; g++) begin : g_word
      always_ff @(posedge clk) begin
        if (rst)                              gate_q[g] <= '0;
        else if (wr_en && widx == IDX_W'(g))  gate_q[g] <= wdata;
      end
    end
  endgenerate
endmodule

// File: rtl/sysctl_unit.sv
module sysctl_unit
  import sysctl_pkg::*;
#(
  parameter bit                         NEW_CLASS      = 1'b1,
  parameter int unsigned                ADDR_W         = 5,
  parameter int unsigned                SCALE_W        = 9,
  parameter int unsigned                IRQ_W          = 7,
  parameter int unsigned                LOCK_BIT       = 6,
  parameter int unsigned                PD_BIT         = 13,
  parameter int unsigned                BOR_W          = 16,
  parameter int unsigned                LDO_W          = 5,
  parameter int unsigned                RSTC_W         = 6,
  parameter int unsigned                GATE_SETS      = 3,
  parameter int unsigned                GATE_PER_SET   = 3,
  parameter logic [31:0]                CFG_RESET_VAL  = 32'h078E_3AC0,
  parameter logic [31:0]                CFG2_RESET_VAL = 32'h0780_2810,
  parameter logic [ID_COUNT*32-1:0]     ID_WORDS       = {32'h0000_0107, 32'h0000_0F3F,
                                                          32'h0107_1013, 32'h0000_30C1,
                                                          32'h001F_001F, 32'h1002_2C11,
                                                          32'h1001_0000}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  output logic               irq,
  output logic [SCALE_W-1:0] clk_scale
);
  localparam int unsigned GATE_N = GATE_SETS * GATE_PER_SET;
  localparam int unsigned IDX_W  = $clog2(GATE_N + 1);

  logic [31:0] addr_u;
  assign addr_u = 32'(addr);

  logic wr_bor, wr_ldo, wr_rstc, wr_cfg, wr_cfg2, wr_mask, wr_mstat, in_gate;
  assign wr_bor   = wr_en && addr_u == A_BOR;
  assign wr_ldo   = wr_en && addr_u == A_LDO;
  assign wr_rstc  = wr_en && addr_u == A_RSTC;
  assign wr_cfg   = wr_en && addr_u == A_CFG;
  assign wr_cfg2  = wr_en && addr_u == A_CFG2;
  assign wr_mask  = wr_en && addr_u == A_MASK;
  assign wr_mstat = wr_en && addr_u == A_MSTAT;
  assign in_gate  = addr_u >= A_GATE && addr_u < A_GATE + GATE_N;

  logic [IDX_W-1:0] gate_idx;
  assign gate_idx = IDX_W'(addr_u - A_GATE);

  logic [BOR_W-1:0]  bor_q;
  logic [LDO_W-1:0]  ldo_q;
  logic [RSTC_W-1:0] rstc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bor_q  <= '0;
      ldo_q  <= '0;
      rstc_q <= '0;
    end else begin
      if (wr_bor)  bor_q  <= wdata[BOR_W-1:0];
      if (wr_ldo)  ldo_q  <= wdata[LDO_W-1:0];
      if (wr_rstc) rstc_q <= wdata[RSTC_W-1:0];
    end
  end

  logic [31:0] cfg_q, cfg2_q;
  logic        lock_set;

  sysctl_clkcfg #(
    .NEW_CLASS(NEW_CLASS), .CFG_RESET_VAL(CFG_RESET_VAL),
    .CFG2_RESET_VAL(CFG2_RESET_VAL), .SCALE_W(SCALE_W), .PD_BIT(PD_BIT)
  ) u_clkcfg (
    .clk(clk), .rst(rst), .wr_cfg(wr_cfg), .wr_cfg2(wr_cfg2), .wdata(wdata),
    .cfg_q(cfg_q), .cfg2_q(cfg2_q), .lock_set(lock_set), .scale(clk_scale)
  );

  logic [IRQ_W-1:0] raw_q, mask_q;

  sysctl_irq #(.IRQ_W(IRQ_W), .LOCK_BIT(LOCK_BIT)) u_irq (
    .clk(clk), .rst(rst), .set_lock(lock_set), .wr_mask(wr_mask), .wr_clr(wr_mstat),
    .wbits(wdata[IRQ_W-1:0]), .raw_q(raw_q), .mask_q(mask_q), .irq(irq)
  );

  logic [31:0] gate_q [GATE_N];

  sysctl_gate #(.GATE_N(GATE_N), .IDX_W(IDX_W)) u_gate (
    .clk(clk), .rst(rst), .wr_en(wr_en && in_gate), .widx(gate_idx),
    .wdata(wdata), .gate_q(gate_q)
  );

  logic [31:0] rd_next;
  logic        unmapped;

  always_comb begin
    rd_next  = '0;
    unmapped = 1'b0;
    case (addr_u)
      A_BOR:   rd_next = 32'(bor_q);
      A_LDO:   rd_next = 32'(ldo_q);
      A_RSTC:  rd_next = 32'(rstc_q);
      A_CFG:   rd_next = cfg_q;
      A_CFG2:  rd_next = cfg2_q;
      A_PLL:   rd_next = 32'(pll_word(NEW_CLASS, cfg_q[9:6]));
      A_RAW:   rd_next = 32'(raw_q);
      A_MASK:  rd_next = 32'(mask_q);
      A_MSTAT: rd_next = 32'(raw_q & mask_q);
      default: begin
        if (in_gate)                rd_next = gate_q[gate_idx];
        else if (addr_u < ID_COUNT) rd_next = ID_WORDS[addr_u*32 +: 32];
        else                        unmapped = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  // R12: an unmapped address returns zero on the following cycle
  a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    unmapped |=> (rdata == '0));

  generate
    if (!NEW_CLASS) begin : g_old_chk
      // R9: an extended-word write in the older class leaves the scale alone
      a_r9_ext_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_cfg2 && !wr_cfg) |=> $stable(clk_scale));
    end
  endgenerate
endmodule

// File: tb/sysctl_unit_test.sv
module sysctl_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] CFG_INIT = 32'h078E_3AC0;
  localparam logic [7*32-1:0] ID_VALS = {32'h1111_0006, 32'h2222_0005, 32'h3333_0004,
                                         32'h4444_0003, 32'h5555_0002, 32'h6666_0001,
                                         32'h7777_0000};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_n, rdata_o;
  logic        irq_n, irq_o;
  logic [8:0]  scale_n, scale_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] rn, ro, cfg;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_unit #(.NEW_CLASS(1'b1), .ID_WORDS(ID_VALS)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata_n), .irq(irq_n), .clk_scale(scale_n));

  sysctl_unit #(.NEW_CLASS(1'b0), .ID_WORDS(ID_VALS)) uut_old (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata_o), .irq(irq_o), .clk_scale(scale_o));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1'b1; addr = 5'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a);
    addr = 5'(a);
    @(negedge clk);
    rn = rdata_n; ro = rdata_o;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(10); check("R1 cfg new", rn, CFG_INIT); check("R1 cfg old", ro, CFG_INIT);
    rd(11); check("R1 cfg2 new", rn, 32'h0780_2810); check("R1 cfg2 old", ro, 32'h0);
    rd(7);  check("R1 bor", rn, 0);
    rd(14); check("R1 mask", rn, 0);
    rd(13); check("R1 raw", rn, 0);
    check("R1 irq", {30'd0, irq_n, irq_o}, 0);
    check("R1 scale new", 32'(scale_n), 80); check("R1 scale old", 32'(scale_o), 80);
    for (int g = 0; g < 9; g++) begin rd(16 + g); check("R1 gate reset", rn, 0); end

    // R7 field widths
    wr(7, 32'hFFFF_FFFF); wr(8, 32'hFFFF_FFFF); wr(9, 32'hFFFF_FFFF);
    rd(7); check("R7 bor", rn, 32'h0000_FFFF);
    rd(8); check("R7 ldo", rn, 32'h0000_001F);
    rd(9); check("R7 rstc", rn, 32'h0000_003F);

    // R10 gating words
    for (int g = 0; g < 9; g++) wr(16 + g, 32'hA500_0000 ^ (32'(g) * 32'h0101_0101));
    for (int g = 0; g < 9; g++) begin
      rd(16 + g); check("R10 gate rw", rn, 32'hA500_0000 ^ (32'(g) * 32'h0101_0101));
    end

    // R11 identification words
    for (int k = 0; k < 7; k++) wr(k, 32'hDEAD_BEEF);
    for (int k = 0; k < 7; k++) begin rd(k); check("R11 id", rn, ID_VALS[k*32 +: 32]); end

    // R2 main divisor sweep
    for (int d = 0; d < 16; d++) begin
      cfg = (CFG_INIT & ~(32'hF << 23)) | (32'(d) << 23);
      wr(10, cfg);
      check("R2 scale new", 32'(scale_n), 32'(5 * (d + 1)));
      check("R2 scale old", 32'(scale_o), 32'(5 * (d + 1)));
    end
    cfg = CFG_INIT; wr(10, cfg);

    // R3 / R9 extended divisor sweep
    for (int d = 0; d < 64; d++) begin
      wr(11, 32'h8000_2000 | (32'(d) << 23));
      check("R3 scale new", 32'(scale_n), 32'(5 * (d + 1)));
      check("R9 scale old", 32'(scale_o), 80);
    end
    rd(11); check("R9 cfg2 old", ro, 0); check("R3 cfg2 new", rn, 32'h9F80_2000);
    wr(11, 32'h0780_2810);
    check("R2 override off", 32'(scale_n), 80);

    // R8 crystal index sweep
    for (int x = 0; x < 16; x++) begin
      cfg = (CFG_INIT & ~(32'hF << 6)) | (32'(x) << 6);
      wr(10, cfg);
      rd(12);
      check("R8 pll new", rn, 32'h0000_C300 + 32'(3 * x));
      check("R8 pll old", ro, 32'h0000_5A00 + 32'(x));
    end

    // R4 / R5 / R6 lock interrupt
    rd(13); check("R4 no spurious new", rn, 0); check("R4 no spurious old", ro, 0);
    cfg = cfg & ~32'h2000; wr(10, cfg);
    rd(13); check("R4 lock new", rn, 32'h40); check("R4 lock old", ro, 32'h40);
    check("R5 irq masked", {31'd0, irq_n}, 0);
    wr(14, 32'hFFFF_FFFF);
    rd(14); check("R5 mask width", rn, 32'h7F);
    check("R5 irq high", {30'd0, irq_n, irq_o}, 32'h3);
    rd(15); check("R5 mstat", rn, 32'h40);
    wr(15, 32'h3F);
    rd(13); check("R6 partial clear", rn, 32'h40);
    wr(15, 32'h40);
    rd(13); check("R6 clear", rn, 0);
    check("R5 irq low", {30'd0, irq_n, irq_o}, 0);
    wr(10, cfg);                     // 0 -> 0
    cfg = cfg | 32'h2000; wr(10, cfg); // 0 -> 1
    wr(10, cfg);                     // 1 -> 1
    rd(13); check("R4 no lock other transitions", rn, 0);
    cfg = cfg & ~32'h2000; wr(10, cfg);
    rd(13); check("R4 lock again", rn, 32'h40);
    wr(15, 32'h7F);
    wr(11, 32'h0780_0810);
    rd(13); check("R4 ext lock new", rn, 32'h40); check("R9 ext lock old", ro, 0);
    check("R5 irq per class", {30'd0, irq_n, irq_o}, 32'h2);

    // R12 unmapped
    for (int a = 25; a < 32; a++) begin
      wr(a, 32'hFFFF_FFFF); rd(a);
      check("R12 unmapped new", rn, 0); check("R12 unmapped old", ro, 0);
    end

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule